// File: doc/BRIEF.md
# Banked Address Space Decoder

This block routes each access on a 16-bit processor address bus to one physical target. The targets are main RAM, auxiliary RAM, the I/O page, the peripheral ROM window, the upper-memory RAM, and one of several ROM pages. The decision depends on the address, on whether the access is a read or a write, and on a set of configuration switches.

The switches are held in registers outside the block. The block itself is purely combinational. Reads and writes can go to different targets for the same address. Two display windows can override the usual main/auxiliary choice while a store-to-display mode is on.

The block also reports several other results:
- which upper-RAM block and 4 KB sub-bank an access uses;
- whether a read finds no installed target, in which case a fixed filler byte is placed on the bus;
- whether a write is thrown away.

The memories, the switch registers and the arbitration of the peripheral window are outside this block.

Top module: `addr_space_decoder`

## Requirements
- R1: `tgt_sel` is one-hot with this bit order: bit 0 main RAM, bit 1 auxiliary RAM, bit 2 I/O, bit 3 peripheral ROM, bit 4 upper RAM, bit 5 ROM. When the decoded target is not installed, `tgt_sel` is all zero. At most one bit is ever set.
- R2: Addresses 0x0000–0x01FF select auxiliary RAM when `sw_zp_aux` is 1 and main RAM otherwise. This holds for reads and for writes alike.
- R3: While `sw_st80` is 1, addresses 0x0400–0x07FF select auxiliary RAM if `sw_page2` is 1 and main RAM if it is 0. This holds regardless of the direction switches.
- R4: While both `sw_st80` and `sw_hires` are 1, addresses 0x2000–0x3FFF follow `sw_page2` in the same way. When `sw_hires` is 0, this window uses the ordinary rule of R5.
- R5: Every other address up to 0xBFFF selects auxiliary RAM when the switch for the current direction is 1: `sw_aux_rd` for a read (`cpu_wr`=0), `sw_aux_wr` for a write (`cpu_wr`=1). Otherwise it selects main RAM.
- R6: Addresses 0xC000–0xC0FF select I/O. Addresses 0xC100–0xCFFF select the peripheral ROM window.
- R7: Addresses 0xD000–0xFFFF select upper RAM when `sw_up_rd` is 1 (reads) or `sw_up_wr` is 1 (writes). Otherwise they select ROM, and `bank_idx` carries `rom_page`.
- R8: A write that decodes to ROM sets `wr_drop`. A read never sets `wr_drop`.
- R9: For upper RAM, `upd_alt` equals `sw_up_alt` for addresses 0xD000–0xDFFF. `upd_alt` is 0 for addresses 0xE000–0xFFFF and for every other target.
- R10: For upper RAM, `bank_idx` is `up_blk_req` modulo UP_BLOCKS. With the default of 6 blocks, a request of 6 gives 0 and a request of 7 gives 1.
- R11: While `sw_zp_aux` is 1, the upper-RAM `bank_idx` is 1, whatever `up_blk_req` holds.
- R12: A read whose target is absent sets `open_bus` and drives `bus_fill` to 0xF4. Otherwise `bus_fill` is 0x00. A target counts as absent in these cases:
  - auxiliary RAM with `aux_fitted`=0;
  - upper RAM with `upram_fitted`=0;
  - a ROM page whose `rom_fitted` bit is 0.
- R13: A write whose target is absent sets `wr_drop` and leaves `open_bus` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | Processor address |
| cpu_wr | input | 1 | 1 = write access, 0 = read access |
| sw_zp_aux | input | 1 | Send the zero/stack area to auxiliary RAM and force upper block 1 |
| sw_st80 | input | 1 | Store-to-display mode enable |
| sw_page2 | input | 1 | Display page 2 selected (routes display windows to auxiliary RAM) |
| sw_hires | input | 1 | Hi-res graphics mode (enables the 0x2000 window override) |
| sw_aux_rd | input | 1 | General RAM reads go to auxiliary RAM |
| sw_aux_wr | input | 1 | General RAM writes go to auxiliary RAM |
| sw_up_rd | input | 1 | Upper area reads go to upper RAM |
| sw_up_wr | input | 1 | Upper area writes go to upper RAM |
| sw_up_alt | input | 1 | Use the second 4 KB bank for 0xD000–0xDFFF |
| up_blk_req | input | REQ_W (3) | Requested upper-RAM block |
| rom_page | input | PG_W (2) | Active ROM page |
| aux_fitted | input | 1 | Auxiliary RAM installed |
| upram_fitted | input | 1 | Upper RAM installed |
| rom_fitted | input | ROM_PAGES (4) | Per-page ROM installed bits |
| tgt_sel | output | 6 | One-hot target select |
| bank_idx | output | BANK_W (3) | Upper block or ROM page, 0 otherwise |
| upd_alt | output | 1 | Second 0xD000 sub-bank in use |
| open_bus | output | 1 | Read of an absent target |
| bus_fill | output | 8 | Filler byte for an open-bus read |
| wr_drop | output | 1 | Write is discarded |

## Verification
The block holds no state, so a wrong routing decision appears at the ports in the same evaluation as the address and switch change that causes it. Most faults show up at region edges. An off-by-one boundary, a crossed read/write switch or a missed display-window override flips `tgt_sel` on exactly one side of a boundary pair. The bench therefore probes both sides of every edge, in both directions. A wrong block reduction or a missing zero-page override shows up only as a wrong `bank_idx` on upper-RAM hits. A presence error shows up as `open_bus` or `wr_drop` disagreeing with `tgt_sel`.

// File: rtl/asd_pkg.sv
package asd_pkg;

    // One-hot bit positions of the target select
    typedef enum logic [2:0] {
        T_MAIN   = 3'd0,
        T_AUX    = 3'd1,
        T_IO     = 3'd2,
        T_PERIPH = 3'd3,
        T_UPRAM  = 3'd4,
        T_ROM    = 3'd5
    } tgt_e;

    localparam int NUM_TGT = 6;

    // Address regions seen by the steering logic
    typedef enum logic [2:0] {
        RG_ZP,      // zero page and stack
        RG_TEXT,    // text display window
        RG_HGR,     // hi-res display window
        RG_LOW,     // remaining general RAM
        RG_IO,      // I/O page
        RG_SLOT,    // peripheral ROM window
        RG_UPD,     // upper area, switchable 4 KB part
        RG_UPEF     // upper area, fixed 8 KB part
    } region_e;

    localparam logic [15:0] ZP_END    = 16'h01FF;
    localparam logic [15:0] TEXT_BEG  = 16'h0400;
    localparam logic [15:0] TEXT_END  = 16'h07FF;
    localparam logic [15:0] HGR_BEG   = 16'h2000;
    localparam logic [15:0] HGR_END   = 16'h3FFF;
    localparam logic [15:0] RAM_END   = 16'hBFFF;
    localparam logic [15:0] IO_END    = 16'hC0FF;
    localparam logic [15:0] SLOT_END  = 16'hCFFF;
    localparam logic [15:0] UPD_END   = 16'hDFFF;

    localparam logic [7:0]  OPEN_BUS_BYTE = 8'hF4;

endpackage

// File: rtl/asd_region_dec.sv
module asd_region_dec
    import asd_pkg::*;
(
    input  logic [15:0] addr,
    output region_e     region
);

    always_comb begin
        if (addr <= ZP_END)
            region = RG_ZP;
        else if (addr >= TEXT_BEG && addr <= TEXT_END)
            region = RG_TEXT;
        else if (addr >= HGR_BEG && addr <= HGR_END)
            region = RG_HGR;
        else if (addr <= RAM_END)
            region = RG_LOW;
        else if (addr <= IO_END)
            region = RG_IO;
        else if (addr <= SLOT_END)
            region = RG_SLOT;
        else if (addr <= UPD_END)
            region = RG_UPD;
        else
            region = RG_UPEF;
    end

endmodule

// File: rtl/asd_low_steer.sv
module asd_low_steer
    import asd_pkg::*;
(
    input  region_e region,
    input  logic    is_wr,
    input  logic    sw_zp_aux,
    input  logic    sw_st80,
    input  logic    sw_page2,
    input  logic    sw_hires,
    input  logic    sw_aux_rd,
    input  logic    sw_aux_wr,
    output logic    want_aux
);

    logic dir_aux;

    assign dir_aux = is_wr ? sw_aux_wr : sw_aux_rd;

    always_comb begin
        unique case (region)
            RG_ZP:   want_aux = sw_zp_aux;
            RG_TEXT: want_aux = sw_st80 ? sw_page2 : dir_aux;
            RG_HGR:  want_aux = (sw_st80 && sw_hires) ? sw_page2 : dir_aux;
            RG_LOW:  want_aux = dir_aux;
            default: want_aux = 1'b0;
        endcase
    end

endmodule

// File: rtl/asd_upper_bank.sv
module asd_upper_bank #(
    parameter int UP_BLOCKS = 6,
    parameter int REQ_W     = 3,
    parameter int BLK_W     = 3
) (
    input  logic [REQ_W-1:0] blk_req,
    input  logic             force_one,
    output logic [BLK_W-1:0] blk
);

    localparam logic [BLK_W-1:0] FORCED = BLK_W'(1 % UP_BLOCKS);

    logic [BLK_W-1:0] reduced;

    generate
        if ((UP_BLOCKS & (UP_BLOCKS - 1)) == 0 && BLK_W <= REQ_W) begin : g_pow2
            assign reduced = blk_req[BLK_W-1:0];
        end else begin : g_mod
            assign reduced = BLK_W'(int'(blk_req) % UP_BLOCKS);
        end
    endgenerate

    assign blk = force_one ? FORCED : reduced;

endmodule

// File: rtl/addr_space_decoder.sv
module addr_space_decoder
    import asd_pkg::*;
#(
    parameter  int UP_BLOCKS = 6,
    parameter  int ROM_PAGES = 4,
    parameter  int REQ_W     = 3,
    localparam int BLK_W     = (UP_BLOCKS > 1) ? $clog2(UP_BLOCKS) : 1,
    localparam int PG_W      = (ROM_PAGES > 1) ? $clog2(ROM_PAGES) : 1,
    localparam int BANK_W    = (BLK_W > PG_W) ? BLK_W : PG_W
) (
    input  logic [15:0]          cpu_addr,
    input  logic                 cpu_wr,
    input  logic                 sw_zp_aux,
    input  logic                 sw_st80,
    input  logic                 sw_page2,
    input  logic                 sw_hires,
    input  logic                 sw_aux_rd,
    input  logic                 sw_aux_wr,
    input  logic                 sw_up_rd,
    input  logic                 sw_up_wr,
    input  logic                 sw_up_alt,
    input  logic [REQ_W-1:0]     up_blk_req,
    input  logic [PG_W-1:0]      rom_page,
    input  logic                 aux_fitted,
    input  logic                 upram_fitted,
    input  logic [ROM_PAGES-1:0] rom_fitted,
    output logic [NUM_TGT-1:0]   tgt_sel,
    output logic [BANK_W-1:0]    bank_idx,
    output logic                 upd_alt,
    output logic                 open_bus,
    output logic [7:0]           bus_fill,
    output logic                 wr_drop
);

    region_e          region;
    logic             want_aux;
    logic [BLK_W-1:0] blk;
    logic             rom_ok;
    logic             up_on;
    tgt_e             tgt;
    logic             present;
    logic [BANK_W-1:0] bank_raw;
    logic             alt_raw;

    asd_region_dec u_region (
        .addr   (cpu_addr),
        .region (region)
    );

    asd_low_steer u_steer (
        .region    (region),
        .is_wr     (cpu_wr),
        .sw_zp_aux (sw_zp_aux),
        .sw_st80   (sw_st80),
        .sw_page2  (sw_page2),
        .sw_hires  (sw_hires),
        .sw_aux_rd (sw_aux_rd),
        .sw_aux_wr (sw_aux_wr),
        .want_aux  (want_aux)
    );

    asd_upper_bank #(
        .UP_BLOCKS (UP_BLOCKS),
        .REQ_W     (REQ_W),
        .BLK_W     (BLK_W)
    ) u_bank (
        .blk_req   (up_blk_req),
        .force_one (sw_zp_aux),
        .blk       (blk)
    );

    // Presence of the selected ROM page
    always_comb begin
        rom_ok = 1'b0;
        for (int p = 0; p < ROM_PAGES; p++) begin
            if (rom_page == PG_W'(p))
                rom_ok = rom_ok | rom_fitted[p];
        end
    end

    assign up_on = cpu_wr ? sw_up_wr : sw_up_rd;

    // Target choice before the presence filter
    always_comb begin
        tgt      = T_MAIN;
        present  = 1'b1;
        bank_raw = '0;
        alt_raw  = 1'b0;
        unique case (region)
            RG_ZP, RG_TEXT, RG_HGR, RG_LOW: begin
                if (want_aux) begin
                    tgt     = T_AUX;
                    present = aux_fitted;
                end
            end
            RG_IO:   tgt = T_IO;
            RG_SLOT: tgt = T_PERIPH;
            RG_UPD, RG_UPEF: begin
                if (up_on) begin
                    tgt      = T_UPRAM;
                    present  = upram_fitted;
                    bank_raw = BANK_W'(blk);
                    alt_raw  = (region == RG_UPD) && sw_up_alt;
                end else begin
                    tgt      = T_ROM;
                    present  = rom_ok;
                    bank_raw = BANK_W'(rom_page);
                end
            end
            default: tgt = T_MAIN;
        endcase
    end

    // Presence filter and bus-level results
    always_comb begin
        tgt_sel  = present ? (NUM_TGT'(1) << tgt) : '0;
        bank_idx = present ? bank_raw : '0;
        upd_alt  = present && alt_raw;
        open_bus = !present && !cpu_wr;
        bus_fill = open_bus ? OPEN_BUS_BYTE : 8'h00;
        wr_drop  = cpu_wr && (!present || tgt == T_ROM);
    end

endmodule

// File: rtl/addr_space_decoder_chk.sv
module addr_space_decoder_chk
    import asd_pkg::*;
#(
    parameter int UP_BLOCKS = 6,
    parameter int BANK_W    = 3
) (
    input logic [15:0]        cpu_addr,
    input logic               cpu_wr,
    input logic               sw_zp_aux,
    input logic [NUM_TGT-1:0] tgt_sel,
    input logic [BANK_W-1:0]  bank_idx,
    input logic               upd_alt,
    input logic               open_bus,
    input logic [7:0]         bus_fill,
    input logic               wr_drop
);

    always_comb begin
        // R1
        sel_onehot_chk: assert ($onehot0(tgt_sel));
        if (cpu_addr <= ZP_END && tgt_sel != '0) begin
            // R2
            zp_route_chk: assert (tgt_sel[T_AUX] == sw_zp_aux);
        end
        if (cpu_addr[15:8] == 8'hC0) begin
            // R6
            io_route_chk: assert (tgt_sel == NUM_TGT'(1 << T_IO));
        end
        if (cpu_wr && tgt_sel[T_ROM]) begin
            // R8
            rom_wr_drop_chk: assert (wr_drop);
        end
        if (cpu_addr > UPD_END) begin
            // R9
            ef_no_alt_chk: assert (!upd_alt);
        end
        if (tgt_sel[T_UPRAM]) begin
            // R10
            blk_range_chk: assert (int'(bank_idx) < UP_BLOCKS);
        end
        if (open_bus) begin
            // R12
            open_fill_chk: assert (tgt_sel == '0 && bus_fill == OPEN_BUS_BYTE && !cpu_wr);
        end
        if (cpu_wr) begin
            // R13
            wr_no_open_chk: assert (!open_bus);
        end
    end

endmodule

bind addr_space_decoder addr_space_decoder_chk #(
    .UP_BLOCKS (UP_BLOCKS),
    .BANK_W    (BANK_W)
) u_chk (
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .sw_zp_aux (sw_zp_aux),
    .tgt_sel   (tgt_sel),
    .bank_idx  (bank_idx),
    .upd_alt   (upd_alt),
    .open_bus  (open_bus),
    .bus_fill  (bus_fill),
    .wr_drop   (wr_drop)
);

// File: tb/test_addr_space_decoder.sv
module test_addr_space_decoder;

    localparam int UPB = 6;

    logic        clk = 1'b0;
    logic [15:0] addr;
    logic        wr;
    logic        zp, st80, pg2, hires, aux_rd, aux_wr, up_rd, up_wr, up_alt;
    logic [2:0]  blk_req;
    logic [1:0]  rpage;
    logic        aux_fit, up_fit;
    logic [3:0]  rom_fit;
    logic [5:0]  sel;
    logic [2:0]  bank;
    logic        dalt, obus, drop;
    logic [7:0]  fill;

    int checked = 0;
    int failed  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    addr_space_decoder i_addr_space_decoder (
        .cpu_addr     (addr),
        .cpu_wr       (wr),
        .sw_zp_aux    (zp),
        .sw_st80      (st80),
        .sw_page2     (pg2),
        .sw_hires     (hires),
        .sw_aux_rd    (aux_rd),
        .sw_aux_wr    (aux_wr),
        .sw_up_rd     (up_rd),
        .sw_up_wr     (up_wr),
        .sw_up_alt    (up_alt),
        .up_blk_req   (blk_req),
        .rom_page     (rpage),
        .aux_fitted   (aux_fit),
        .upram_fitted (up_fit),
        .rom_fitted   (rom_fit),
        .tgt_sel      (sel),
        .bank_idx     (bank),
        .upd_alt      (dalt),
        .open_bus     (obus),
        .bus_fill     (fill),
        .wr_drop      (drop)
    );

    task automatic defaults();
        zp = 0; st80 = 0; pg2 = 0; hires = 0; aux_rd = 0; aux_wr = 0;
        up_rd = 0; up_wr = 0; up_alt = 0; blk_req = 0; rpage = 0;
        aux_fit = 1; up_fit = 1; rom_fit = 4'hF; addr = 0; wr = 0;
    endtask

    // Drive one access, compute the expected routing from the requirements, compare all outputs
    task automatic probe(input logic [15:0] a, input logic w, input string tag);
        int   t;
        bit   pres, ea;
        logic [5:0] esel;
        logic [2:0] ebank;
        logic [7:0] efill;
        bit   eobus, edrop, ealt;
        @(negedge clk);
        addr = a; wr = w;
        #2;
        ebank = 0; ealt = 0; pres = 1;
        if (a <= 16'h01FF) ea = zp;
        else if (st80 && a >= 16'h0400 && a <= 16'h07FF) ea = pg2;
        else if (st80 && hires && a >= 16'h2000 && a <= 16'h3FFF) ea = pg2;
        else ea = w ? aux_wr : aux_rd;
        if (a <= 16'hBFFF) begin
            t = ea ? 1 : 0;
            if (ea) pres = aux_fit;
        end else if (a <= 16'hC0FF) t = 2;
        else if (a <= 16'hCFFF) t = 3;
        else if (w ? up_wr : up_rd) begin
            t = 4; pres = up_fit;
            ebank = zp ? 3'd1 : 3'(int'(blk_req) % UPB);
            ealt = (a <= 16'hDFFF) && up_alt;
        end else begin
            t = 5; pres = rom_fit[rpage];
            ebank = {1'b0, rpage};
        end
        if (!pres) begin ebank = 0; ealt = 0; end
        esel  = pres ? (6'b1 << t) : 6'b0;
        eobus = !pres && !w;
        efill = eobus ? 8'hF4 : 8'h00;
        edrop = w && (!pres || t == 5);
        checked++;
        if (sel !== esel || bank !== ebank || dalt !== ealt || obus !== eobus ||
            fill !== efill || drop !== edrop) begin
            failed++;
            $display("FAIL %s addr=%h wr=%0d: sel=%b bank=%0d alt=%0d ob=%0d fill=%h drop=%0d expected sel=%b bank=%0d alt=%0d ob=%0d fill=%h drop=%0d",
                     tag, a, w, sel, bank, dalt, obus, fill, drop,
                     esel, ebank, ealt, eobus, efill, edrop);
        end
    endtask

    task automatic t_reset_state();   // R1
        defaults();
        probe(16'h0000, 0, "R1 idle");
        probe(16'h1234, 1, "R1 idle write");
    endtask

    task automatic t_zero_page();     // R2
        defaults(); zp = 1;
        probe(16'h01FF, 0, "R2 zp top");
        probe(16'h0200, 0, "R2 above zp");
        probe(16'h0000, 1, "R2 zp write");
        zp = 0;
        probe(16'h01FF, 1, "R2 zp off");
    endtask

    task automatic t_display();       // R3 R4
        defaults(); st80 = 1; pg2 = 1;
        probe(16'h03FF, 0, "R3 below text");
        probe(16'h0400, 0, "R3 text start");
        probe(16'h07FF, 1, "R3 text end write");
        probe(16'h0800, 0, "R3 above text");
        probe(16'h2000, 0, "R4 hires off");
        hires = 1;
        probe(16'h1FFF, 0, "R4 below hgr");
        probe(16'h2000, 1, "R4 hgr start");
        probe(16'h3FFF, 0, "R4 hgr end");
        probe(16'h4000, 0, "R4 above hgr");
        pg2 = 0; aux_rd = 1;
        probe(16'h0500, 0, "R3 page1 override");
        st80 = 0;
        probe(16'h0500, 0, "R3 store off");
    endtask

    task automatic t_split();         // R5
        defaults(); aux_rd = 1;
        probe(16'h0200, 0, "R5 read aux");
        probe(16'h0200, 1, "R5 write main");
        aux_rd = 0; aux_wr = 1;
        probe(16'hBFFF, 1, "R5 write aux top");
        probe(16'hBFFF, 0, "R5 read main top");
    endtask

    task automatic t_cpage();         // R6
        defaults(); aux_rd = 1;
        probe(16'hC000, 0, "R6 io start");
        probe(16'hC0FF, 1, "R6 io end");
        probe(16'hC100, 0, "R6 periph start");
        probe(16'hCFFF, 0, "R6 periph end");
        probe(16'hD000, 0, "R6 rom after periph");
    endtask

    task automatic t_upper();         // R7 R8 R9
        defaults(); up_rd = 1; up_alt = 1; rpage = 2'd2; blk_req = 3'd3;
        probe(16'hD000, 0, "R9 d alt read");
        probe(16'hDFFF, 0, "R9 d alt end");
        probe(16'hE000, 0, "R9 ef no alt");
        probe(16'hFFFF, 0, "R9 ef top");
        probe(16'hD000, 1, "R8 write to rom");
        probe(16'hF000, 1, "R8 write to rom ef");
        up_wr = 1; up_rd = 0;
        probe(16'hD800, 1, "R7 write upram");
        probe(16'hE800, 0, "R7 read rom page");
        up_alt = 0;
        probe(16'hD000, 1, "R9 d main bank");
    endtask

    task automatic t_blocks();        // R10 R11
        defaults(); up_rd = 1;
        blk_req = 3'd5; probe(16'hE000, 0, "R10 block 5");
        blk_req = 3'd6; probe(16'hE000, 0, "R10 block 6 wraps");
        blk_req = 3'd7; probe(16'hD000, 0, "R10 block 7 wraps");
        blk_req = 3'd4; zp = 1;
        probe(16'hE000, 0, "R11 zp forces 1");
        blk_req = 3'd0;
        probe(16'hD000, 0, "R11 zp forces 1 from 0");
    endtask

    task automatic t_absent();        // R12 R13
        defaults(); aux_fit = 0; aux_rd = 1; aux_wr = 1;
        probe(16'h3000, 0, "R12 aux absent read");
        probe(16'h3000, 1, "R13 aux absent write");
        aux_rd = 0;
        probe(16'h3000, 0, "R12 main still there");
        defaults(); rom_fit = 4'b1011; rpage = 2'd2;
        probe(16'hE000, 0, "R12 rom page absent");
        rpage = 2'd3;
        probe(16'hE000, 0, "R12 rom page present");
        defaults(); up_fit = 0; up_wr = 1; up_rd = 1;
        probe(16'hD000, 1, "R13 upram absent write");
        probe(16'hD000, 0, "R12 upram absent read");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checked++; failed++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checked, failed);
            $finish;
        end
    end

    initial begin
        defaults();
        repeat (2) @(posedge clk);
        t_reset_state();
        t_zero_page();
        t_display();
        t_split();
        t_cpage();
        t_upper();
        t_blocks();
        t_absent();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checked, failed);
        $finish;
    end

endmodule